// File: doc/BRIEF.md
# Watch-Mode Power Sequencer

This block decides when a small microcontroller drops into its low-power watch mode and how it comes back out. A sleep request from the CPU while running at full speed enters watch mode only when three standby-control bits hold a particular combination. In watch mode the CPU clock, the main oscillator and every peripheral clock enable are switched off, except the enables for the infrared receiver and the secondary watchdog. A fixed small set of clock domains therefore keeps running.

A wake-up comes from NMI or from any of several interrupt source classes. These are external IRQ lines, key inputs, wake-up event inputs, and peripheral interrupts (watchdog overflow, PS/2, infrared receiver). Each maskable source must be individually enabled, and the CPU must not be masking interrupts. NMI cannot be masked. The exit target is chosen when watch mode is entered. A full-speed exit restarts the oscillator and waits a programmable settling time of 2^(SETTLE_BASE+code) cycles before interrupt handling may start. A medium-speed exit starts interrupt handling at once. The reset pin acts asynchronously: it turns every clock back on, and reset handling is signalled only after the pin is released.

States: `ST_RESET` (pin held low), `ST_RSTEXC` (reset handling start), `ST_HS` (high speed), `ST_MS` (medium speed), `ST_WATCH`, `ST_SETTLE` (oscillator settling), `ST_IRQGO` (interrupt handling start).

Transitions:
- RESET→RSTEXC on release
- RSTEXC→HS
- HS→WATCH on a qualified sleep request
- MS→HS on `fast_req`
- WATCH→SETTLE on wake with a full-speed target
- WATCH→IRQGO on wake with a medium-speed target
- SETTLE→IRQGO when the counter expires
- IRQGO→HS or IRQGO→MS, by the target
- any state→RESET while `res_n` is low

Top module: `wmode_ctrl`

## Requirements
- R1: From `ST_HS`, a one-cycle `sleep_req` with `ssby`=1, `dton`=0 and `pss`=1 sets `in_watch` at the next clock edge.
- R2: A `sleep_req` with any other combination of `ssby`/`dton`/`pss`, or a `sleep_req` made in medium-speed mode, leaves all clocks enabled and does not enter watch mode; medium-speed mode persists.
- R3: While `in_watch`=1, `cpu_clk_en`=0 and `osc_en`=0, and `pclk_en` equals a mask with only bit IR_IDX (default 0, infrared receiver) and bit WDT_IDX (default 1, secondary watchdog) set.
- R4: An IRQ, key, wake-event or peripheral-interrupt input wakes the block only when its own enable bit is 1 and `cpu_mask`=0; otherwise watch mode is kept.
- R5: `nmi`=1 in watch mode always wakes, even with `cpu_mask`=1 and all enables 0.
- R6: With a full-speed target, wake is followed by exactly 2^(SETTLE_BASE+`sts_code`) cycles with `osc_en`=1 and `cpu_clk_en`=0. Then `irq_start` pulses for one cycle with all clocks on, and high speed follows (`mode_medium`=0).
- R7: With a medium-speed target, `irq_start` pulses in the cycle after wake, with no settling cycles, and `mode_medium`=1 from then on until a `fast_req` returns to high speed.
- R8: While `res_n`=0, `osc_en`, `cpu_clk_en` and all `pclk_en` bits are 1 at once (asynchronously) and `rst_start`=0. `rst_start` is 1 for exactly the first cycle after release, then high speed follows.
- R9: The exit target is the `medium_sel` value sampled with the entering sleep request; later changes of `medium_sel` have no effect on the exit path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| res_n | input | 1 | Reset pin, active low, asynchronous |
| sleep_req | input | 1 | One-cycle pulse: CPU executed a sleep instruction |
| ssby | input | 1 | Standby-select control bit |
| dton | input | 1 | Direct-transfer control bit |
| pss | input | 1 | Watchdog clock-select control bit |
| medium_sel | input | 1 | 1 selects medium-speed exit, sampled at entry |
| fast_req | input | 1 | Return from medium speed to high speed |
| sts_code | input | 3 | Settling-time code |
| cpu_mask | input | 1 | CPU interrupt mask (1 = masked) |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | N_IRQ | External IRQ lines |
| irq_en | input | N_IRQ | Per-line IRQ enables |
| key | input | N_KEY | Key inputs |
| key_en | input | N_KEY | Per-key input enables |
| wue | input | N_WUE | Wake-up event inputs |
| wue_en | input | N_WUE | Per-event input enables |
| peri_irq | input | N_PERI | Peripheral interrupts (watchdog overflow, PS/2, IR) |
| peri_ie | input | N_PERI | Peripheral interrupt enables |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| pclk_en | output | N_PCLK | Peripheral clock enables |
| in_watch | output | 1 | Watch mode active |
| mode_medium | output | 1 | Running in medium-speed mode |
| irq_start | output | 1 | One-cycle pulse: begin interrupt handling |
| rst_start | output | 1 | One-cycle pulse: begin reset handling |

## Verification
Entry is tried with random standby-bit combinations that are biased toward the valid one. This separates the single entering combination from its near misses, and a sleep request in medium speed shows that entry is tied to high speed. Wake is tried with sparse random source and enable vectors under a random CPU mask. These patterns tell a correctly gated per-source wake apart from a raw OR of the inputs or an ignored mask. NMI under full masking shows that it bypasses the mask. Full-speed exits with random settling codes measure the exact settle length per code, and medium-speed exits and a late `medium_sel` flip show that the target is latched at entry.

// File: rtl/wmode_pkg.sv
package wmode_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_RSTEXC,
        ST_HS,
        ST_MS,
        ST_WATCH,
        ST_SETTLE,
        ST_IRQGO
    } wm_state_t;

    // Clock-control word produced by the output decoder
    typedef struct packed {
        logic osc;
        logic cpu;
        logic periph_all;
        logic periph_keep;
    } clk_ctl_t;

endpackage

// File: rtl/wmode_wake_qual.sv
module wmode_wake_qual #(
    parameter int N_IRQ  = 16,
    parameter int N_KEY  = 16,
    parameter int N_WUE  = 8,
    parameter int N_PERI = 3
) (
    input  logic              cpu_mask,
    input  logic              nmi,
    input  logic [N_IRQ-1:0]  irq,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [N_KEY-1:0]  key,
    input  logic [N_KEY-1:0]  key_en,
    input  logic [N_WUE-1:0]  wue,
    input  logic [N_WUE-1:0]  wue_en,
    input  logic [N_PERI-1:0] peri_irq,
    input  logic [N_PERI-1:0] peri_ie,
    output logic              wake
);
    logic irq_hit, key_hit, wue_hit, peri_hit, maskable;

    always_comb begin
        irq_hit  = |(irq & irq_en);
        key_hit  = |(key & key_en);
        wue_hit  = |(wue & wue_en);
        peri_hit = |(peri_irq & peri_ie);
        maskable = irq_hit | key_hit | wue_hit | peri_hit;
        // NMI bypasses the CPU mask
        wake     = nmi | (maskable & ~cpu_mask);
    end
endmodule

// File: rtl/wmode_settle_cnt.sv
module wmode_settle_cnt #(
    parameter int SETTLE_BASE = 8,
    parameter int CODE_W      = 3
) (
    input  logic              clk,
    input  logic              res_n,
    input  logic              load,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int MAX_EXP = SETTLE_BASE + (1 << CODE_W) - 1;
    localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;

    logic [CNT_W-1:0] cnt;

    // Loaded with N-1 so that the settle state lasts exactly N cycles
    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(((CNT_W+1)'(1) << (SETTLE_BASE + 32'(code))) - 1'b1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/wmode_pclk_gate.sv
module wmode_pclk_gate #(
    parameter int N_PCLK  = 8,
    parameter int IR_IDX  = 0,
    parameter int WDT_IDX = 1
) (
    input  logic              all_on,
    input  logic              keep_on,
    output logic [N_PCLK-1:0] pclk_en
);
    for (genvar i = 0; i < N_PCLK; i++) begin : g_pclk
        if (i == IR_IDX || i == WDT_IDX) begin : g_keep
            assign pclk_en[i] = keep_on;
        end else begin : g_gated
            assign pclk_en[i] = all_on;
        end
    end
endmodule

// File: rtl/wmode_ctrl.sv
module wmode_ctrl
    import wmode_pkg::*;
#(
    parameter int N_IRQ       = 16,
    parameter int N_KEY       = 16,
    parameter int N_WUE       = 8,
    parameter int N_PERI      = 3,
    parameter int N_PCLK      = 8,
    parameter int IR_IDX      = 0,
    parameter int WDT_IDX     = 1,
    parameter int SETTLE_BASE = 8,
    parameter int STS_W       = 3
) (
    input  logic              clk,
    input  logic              res_n,
    input  logic              sleep_req,
    input  logic              ssby,
    input  logic              dton,
    input  logic              pss,
    input  logic              medium_sel,
    input  logic              fast_req,
    input  logic [STS_W-1:0]  sts_code,
    input  logic              cpu_mask,
    input  logic              nmi,
    input  logic [N_IRQ-1:0]  irq,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [N_KEY-1:0]  key,
    input  logic [N_KEY-1:0]  key_en,
    input  logic [N_WUE-1:0]  wue,
    input  logic [N_WUE-1:0]  wue_en,
    input  logic [N_PERI-1:0] peri_irq,
    input  logic [N_PERI-1:0] peri_ie,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic [N_PCLK-1:0] pclk_en,
    output logic              in_watch,
    output logic              mode_medium,
    output logic              irq_start,
    output logic              rst_start
);
    wm_state_t state, state_nx;
    logic      exit_ms;
    logic      wake, settle_done, cnt_load, cnt_run, entry_ok;
    clk_ctl_t  cc;

    wmode_wake_qual #(
        .N_IRQ(N_IRQ), .N_KEY(N_KEY), .N_WUE(N_WUE), .N_PERI(N_PERI)
    ) u_wake (
        .cpu_mask(cpu_mask), .nmi(nmi),
        .irq(irq), .irq_en(irq_en),
        .key(key), .key_en(key_en),
        .wue(wue), .wue_en(wue_en),
        .peri_irq(peri_irq), .peri_ie(peri_ie),
        .wake(wake)
    );

    wmode_settle_cnt #(
        .SETTLE_BASE(SETTLE_BASE), .CODE_W(STS_W)
    ) u_settle (
        .clk(clk), .res_n(res_n),
        .load(cnt_load), .run(cnt_run),
        .code(sts_code), .done(settle_done)
    );

    wmode_pclk_gate #(
        .N_PCLK(N_PCLK), .IR_IDX(IR_IDX), .WDT_IDX(WDT_IDX)
    ) u_pclk (
        .all_on(cc.periph_all), .keep_on(cc.periph_keep), .pclk_en(pclk_en)
    );

    assign entry_ok = ssby & ~dton & pss;

    // Next-state logic
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        unique case (state)
            ST_RESET:  state_nx = ST_RSTEXC;
            ST_RSTEXC: state_nx = ST_HS;
            ST_HS:     if (sleep_req && entry_ok) state_nx = ST_WATCH;
            ST_MS:     if (fast_req) state_nx = ST_HS;
            ST_WATCH: begin
                if (wake) begin
                    if (exit_ms) begin
                        state_nx = ST_IRQGO;
                    end else begin
                        state_nx = ST_SETTLE;
                        cnt_load = 1'b1;
                    end
                end
            end
            ST_SETTLE: if (settle_done) state_nx = ST_IRQGO;
            ST_IRQGO:  state_nx = exit_ms ? ST_MS : ST_HS;
            default:   state_nx = ST_RESET;
        endcase
    end

    // State register, exit target latched on entry
    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) begin
            state   <= ST_RESET;
            exit_ms <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_HS && state_nx == ST_WATCH) begin
                exit_ms <= medium_sel;
            end
        end
    end

    // Output decoder
    always_comb begin
        cc          = '{osc: 1'b1, cpu: 1'b1, periph_all: 1'b1, periph_keep: 1'b1};
        in_watch    = 1'b0;
        mode_medium = 1'b0;
        irq_start   = 1'b0;
        rst_start   = 1'b0;
        cnt_run     = 1'b0;
        unique case (state)
            ST_RESET:  ;
            ST_RSTEXC: rst_start = 1'b1;
            ST_HS:     ;
            ST_MS:     mode_medium = 1'b1;
            ST_WATCH: begin
                cc       = '{osc: 1'b0, cpu: 1'b0, periph_all: 1'b0, periph_keep: 1'b1};
                in_watch = 1'b1;
            end
            ST_SETTLE: begin
                cc      = '{osc: 1'b1, cpu: 1'b0, periph_all: 1'b0, periph_keep: 1'b1};
                cnt_run = 1'b1;
            end
            ST_IRQGO: begin
                irq_start   = 1'b1;
                mode_medium = exit_ms;
            end
            default: ;
        endcase
    end

    // Reset pin forces every clock on without waiting for an edge
    assign osc_en     = cc.osc | ~res_n;
    assign cpu_clk_en = cc.cpu | ~res_n;
endmodule

// File: rtl/wmode_ctrl_chk.sv
module wmode_ctrl_chk #(
    parameter int N_PCLK  = 8,
    parameter int IR_IDX  = 0,
    parameter int WDT_IDX = 1
) (
    input logic              clk,
    input logic              res_n,
    input logic              sleep_req,
    input logic              ssby,
    input logic              dton,
    input logic              pss,
    input logic              cpu_mask,
    input logic              nmi,
    input logic              in_watch,
    input logic              osc_en,
    input logic              cpu_clk_en,
    input logic [N_PCLK-1:0] pclk_en,
    input logic              irq_start,
    input logic              rst_start
);
    localparam logic [N_PCLK-1:0] KEEP =
        (N_PCLK'(1) << IR_IDX) | (N_PCLK'(1) << WDT_IDX);

    assert_entry_R1: assert property (@(posedge clk) disable iff (!res_n)
        $rose(in_watch) |-> $past(sleep_req && ssby && !dton && pss));

    assert_gates_R3: assert property (@(posedge clk) disable iff (!res_n)
        in_watch |-> (!cpu_clk_en && !osc_en && pclk_en == KEEP));

    assert_masked_stay_R4: assert property (@(posedge clk) disable iff (!res_n)
        (in_watch && !nmi && cpu_mask) |=> in_watch);

    assert_nmi_wake_R5: assert property (@(posedge clk) disable iff (!res_n)
        (in_watch && nmi) |=> !in_watch);

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!res_n)
        irq_start |=> !irq_start);

    assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!res_n)
        rst_start |=> (!rst_start && cpu_clk_en && osc_en));

    always_comb begin
        if (!res_n) begin
            assert_reset_clocks_R8: assert (cpu_clk_en && osc_en);
        end
    end
endmodule

bind wmode_ctrl wmode_ctrl_chk #(
    .N_PCLK(N_PCLK), .IR_IDX(IR_IDX), .WDT_IDX(WDT_IDX)
) u_chk (
    .clk(clk), .res_n(res_n), .sleep_req(sleep_req),
    .ssby(ssby), .dton(dton), .pss(pss),
    .cpu_mask(cpu_mask), .nmi(nmi), .in_watch(in_watch),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .pclk_en(pclk_en),
    .irq_start(irq_start), .rst_start(rst_start)
);

// File: tb/wmode_ctrl_tb.sv
module wmode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 2;

    logic clk = 1'b0, res_n = 1'b0;
    logic sleep_req = 0, ssby = 0, dton = 0, pss = 0, medium_sel = 0, fast_req = 0;
    logic [2:0]  sts_code = 0;
    logic        cpu_mask = 0, nmi = 0;
    logic [15:0] irq = 0, irq_en = 0, key = 0, key_en = 0;
    logic [7:0]  wue = 0, wue_en = 0;
    logic [2:0]  peri_irq = 0, peri_ie = 0;
    logic        osc_en, cpu_clk_en, in_watch, mode_medium, irq_start, rst_start;
    logic [7:0]  pclk_en;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wmode_ctrl #(.SETTLE_BASE(BASE)) u_dut (
        .clk(clk), .res_n(res_n), .sleep_req(sleep_req), .ssby(ssby), .dton(dton),
        .pss(pss), .medium_sel(medium_sel), .fast_req(fast_req), .sts_code(sts_code),
        .cpu_mask(cpu_mask), .nmi(nmi), .irq(irq), .irq_en(irq_en), .key(key),
        .key_en(key_en), .wue(wue), .wue_en(wue_en), .peri_irq(peri_irq),
        .peri_ie(peri_ie), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .pclk_en(pclk_en),
        .in_watch(in_watch), .mode_medium(mode_medium), .irq_start(irq_start),
        .rst_start(rst_start)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_wake();
        bit m;
        m = |(irq & irq_en) || |(key & key_en) || |(wue & wue_en) || |(peri_irq & peri_ie);
        return nmi || (m && !cpu_mask);
    endfunction

    function automatic logic [15:0] sparse16();
        return 16'(1 << $urandom_range(15, 0)) & {16{$urandom_range(1, 0) == 1}};
    endfunction

    task automatic clear_src();
        nmi = 0; irq = 0; irq_en = 0; key = 0; key_en = 0;
        wue = 0; wue_en = 0; peri_irq = 0; peri_ie = 0; cpu_mask = 0;
    endtask

    // Called at a negedge while in high speed
    task automatic enter(input bit ms);
        ssby = 1; dton = 0; pss = 1; medium_sel = ms; sleep_req = 1;
        @(negedge clk);
        sleep_req = 0;
        check("R1 enter", in_watch, 1);
        check("R3 gating", {cpu_clk_en, osc_en, pclk_en}, {2'b00, 8'h03});
    endtask

    // Called one negedge after the waking edge
    task automatic finish_exit(input bit ms);
        int n;
        if (ms) begin
            check("R7 irq_start immediate", irq_start, 1);
            @(negedge clk);
            check("R7 medium mode", {mode_medium, irq_start, cpu_clk_en}, 3'b101);
            fast_req = 1;
            @(negedge clk);
            fast_req = 0;
            check("R7 back to high speed", mode_medium, 0);
        end else begin
            n = 0;
            while (!irq_start && n < 5000) begin
                if (cpu_clk_en !== 1'b0 || osc_en !== 1'b1)
                    check("R6 settle gating", {cpu_clk_en, osc_en}, 2'b01);
                n++;
                @(negedge clk);
            end
            check("R6 settle length", n, 1 << (BASE + sts_code));
            check("R6 clocks at irq_start", {cpu_clk_en, osc_en, pclk_en}, {2'b11, 8'hFF});
            @(negedge clk);
            check("R6 high speed after", {irq_start, mode_medium, cpu_clk_en}, 3'b001);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #(CLK_PERIOD * 2 + 1);
        check("R8 clocks in reset", {osc_en, cpu_clk_en, pclk_en, rst_start}, {2'b11, 8'hFF, 1'b0});
        @(negedge clk);
        res_n = 1;
        @(negedge clk);
        check("R8 rst_start pulse", rst_start, 1);
        @(negedge clk);
        check("R8 then high speed", {rst_start, in_watch, mode_medium}, 3'b000);

        // Medium-speed sleep is ignored (R2)
        enter(1'b1);
        nmi = 1;
        @(negedge clk);
        nmi = 0;
        finish_exit(1'b1);
        enter(1'b1);
        nmi = 1;
        @(negedge clk);
        nmi = 0;
        check("R7 irq_start", irq_start, 1);
        @(negedge clk);
        ssby = 1; dton = 0; pss = 1; sleep_req = 1;
        @(negedge clk);
        sleep_req = 0;
        check("R2 sleep in medium ignored", {in_watch, mode_medium, cpu_clk_en}, 3'b011);
        fast_req = 1;
        @(negedge clk);
        fast_req = 0;

        // Late change of medium_sel (R9)
        sts_code = 3'd1;
        enter(1'b0);
        medium_sel = 1;
        @(negedge clk);
        nmi = 1; cpu_mask = 1;
        @(negedge clk);
        clear_src();
        check("R5 nmi under mask", in_watch, 0);
        check("R9 target latched", irq_start, 0);
        finish_exit(1'b0);

        // Reset pin during watch (R8)
        enter(1'b0);
        #(CLK_PERIOD/4);
        res_n = 0;
        #1;
        check("R8 async clocks on", {osc_en, cpu_clk_en, pclk_en, rst_start}, {2'b11, 8'hFF, 1'b0});
        @(negedge clk);
        res_n = 1;
        @(negedge clk);
        check("R8 rst_start after release", {rst_start, in_watch}, 2'b10);
        @(negedge clk);
        check("R8 pulse one cycle", rst_start, 0);

        // Random trials
        for (int t = 0; t < 60; t++) begin
            bit ok, ms, w;
            ssby = ($urandom_range(3, 0) != 0);
            dton = ($urandom_range(3, 0) == 0);
            pss  = ($urandom_range(3, 0) != 0);
            ms   = $urandom_range(1, 0);
            medium_sel = ms;
            sts_code = 3'($urandom_range(7, 0));
            ok = ssby && !dton && pss;
            sleep_req = 1;
            @(negedge clk);
            sleep_req = 0;
            if (!ok) begin
                check("R2 blocked entry", {in_watch, cpu_clk_en, osc_en, pclk_en}, {3'b011, 8'hFF});
                continue;
            end
            check("R1 random enter", in_watch, 1);
            check("R3 random gating", {cpu_clk_en, osc_en, pclk_en}, {2'b00, 8'h03});
            w = 0;
            for (int a = 0; a < 4 && !w; a++) begin
                irq = sparse16(); irq_en = sparse16() | ($urandom_range(1, 0) ? irq : 16'h0);
                key = sparse16(); key_en = sparse16();
                wue = 8'(sparse16()); wue_en = 8'(sparse16());
                peri_irq = 3'($urandom_range(7, 0)) & {3{$urandom_range(1, 0) == 1}};
                peri_ie  = 3'($urandom_range(7, 0));
                cpu_mask = ($urandom_range(2, 0) == 0);
                nmi = 0;
                w = exp_wake();
                @(negedge clk);
                clear_src();
                check("R4 qualified wake", in_watch, !w);
            end
            if (!w) begin
                nmi = 1;
                @(negedge clk);
                nmi = 0;
                check("R5 nmi wake", in_watch, 0);
            end
            finish_exit(ms);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule